// File: doc/BRIEF.md
# ADC auto-trigger source selector

This block decides the clock cycle in which an analog-to-digital conversion begins. A 3-bit selection field chooses one trigger source. The choices are a set of single-bit event flags raised by neighbouring peripherals, or the converter's own conversion-complete flag for free-running operation. The block watches the chosen signal for a rising edge. It then issues a one-cycle start pulse, but only if the converter enable and the auto-trigger enable are both set and the converter is idle.

The edge detector sits after the multiplexer. Moving the selection from a low source to a high source therefore counts as an edge and requests a conversion. Moving the selection into free-running mode is the exception: it never produces a start, even when the conversion-complete flag is already high. Once in free-running mode, each new rise of the conversion-complete flag starts the next conversion.

Top module: `adc_trig_sel`

## Requirements
- R1: While rst_ni is low, start_o is 0. The stored previous value of the selected signal resets to 0, so a selected flag that is already high when reset is released gives exactly one start.
- R2: Selection codes: 0 selects free running (conversion-complete flag), and 1 to 6 select flags_i bit 0 to bit 5 (1 analog comparator, 2 external interrupt 0, 3 timer 0 compare A, 4 timer 0 overflow, 5 timer 0 compare B, 6 pin change).
- R3: A start is requested only on a 0-to-1 change of the selected signal. A flag that stays high, and changes on unselected flags, request nothing.
- R4: With auto_en_i low, no start is issued whatever the selection and the flags do.
- R5: With conv_en_i low, a trigger is dropped. It is not replayed when conv_en_i is set later.
- R6: Changing the selection from a source whose signal is low to one whose signal is high requests a start.
- R7: Changing the selection to code 0 never requests a start, even if conv_done_i is already high.
- R8: While code 0 stays selected, a rise of conv_done_i gives a start, provided both enables are set.
- R9: A trigger that arrives while busy_i is high is ignored and is not queued.
- R10: Code 7 selects no source and never produces a start.
- R11: start_o is high for exactly one cycle, in the cycle after the clock edge that sampled the trigger. It never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_en_i | input | 1 | Converter enable |
| auto_en_i | input | 1 | Auto-trigger enable |
| src_sel_i | input | 3 | Trigger source selection code |
| flags_i | input | 6 | Peripheral event flags, bit k is selection k+1 |
| conv_done_i | input | 1 | Conversion-complete flag |
| busy_i | input | 1 | Conversion in progress |
| start_o | output | 1 | One-cycle start-conversion pulse |

## Verification
The bench steps through a table of selection changes. Some move from a low source to a high one, some move from a high source to a high one, some move into free running while conv_done_i is high, and some select code 7. A design that detected edges before the multiplexer would miss the low-to-high switch. A design that did not track entry into free running would fire spuriously. Further vectors show that a trigger swallowed by a disabled enable or by busy_i is not replayed later, which catches a design that latches a pending request. Directed tests hold a flag high across reset, where a design that reset the history register to 1 would stay silent. They also run ten back-to-back free-running conversions and expect exactly ten starts.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned NUM_FLAGS = 6;

  typedef enum logic [SEL_W-1:0] {
    SRC_FREE     = 3'd0,
    SRC_ACMP     = 3'd1,
    SRC_EXT0     = 3'd2,
    SRC_TMR0_CMA = 3'd3,
    SRC_TMR0_OVF = 3'd4,
    SRC_TMR0_CMB = 3'd5,
    SRC_PINCHG   = 3'd6,
    SRC_NONE     = 3'd7
  } trig_src_e;
endpackage

// File: rtl/adc_trig_mux.sv
module adc_trig_mux #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned NUM_FLAGS = 6
) (
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 done_i,
  output logic                 sig_o
);
  localparam int unsigned NUM_CODES = 1 << SEL_W;

  logic [NUM_CODES-1:0] cand;

  // code 0: conversion complete; 1..NUM_FLAGS: flags; rest tied low
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_cand
    if (i == 0) begin : g_free
      assign cand[i] = done_i;
    end else if (i <= NUM_FLAGS) begin : g_flag
      assign cand[i] = flags_i[i-1];
    end else begin : g_none
      assign cand[i] = 1'b0;
    end
  end

  assign sig_o = cand[sel_i];
endmodule

// File: rtl/adc_trig_edge.sv
module adc_trig_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic free_i,
  output logic trig_o
);
  logic prev_q;
  logic free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      free_q <= 1'b0;
    end else begin
      prev_q <= sig_i;
      free_q <= free_i;
    end
  end

  // entering free-running mode is masked; staying in it is not
  assign trig_o = sig_i & ~prev_q & (~free_i | free_q);

  // R11
  trig_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 conv_en_i,
  input  logic                 auto_en_i,
  input  logic [SEL_W-1:0]     src_sel_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 conv_done_i,
  input  logic                 busy_i,
  output logic                 start_o
);
  logic sel_sig;
  logic trig;
  logic start_q;

  adc_trig_mux #(
    .SEL_W    (SEL_W),
    .NUM_FLAGS(NUM_FLAGS)
  ) u_mux (
    .sel_i  (src_sel_i),
    .flags_i(flags_i),
    .done_i (conv_done_i),
    .sig_o  (sel_sig)
  );

  adc_trig_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (sel_sig),
    .free_i(src_sel_i == SRC_FREE),
    .trig_o(trig)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= trig & auto_en_i & conv_en_i & ~busy_i;
  end

  assign start_o = start_q;

  // R4 R5
  enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(conv_en_i && auto_en_i));

  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !$past(busy_i));

  // R10
  no_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> ($past(src_sel_i) != SRC_NONE));

  // R11
  pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

// File: tb/adc_trig_sel_test.sv
module adc_trig_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_en = 1'b0;
  logic       auto_en = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [5:0] flags = 6'd0;
  logic       done = 1'b0;
  logic       busy = 1'b0;
  logic       start;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_trig_sel uut (
    .clk_i(clk), .rst_ni(rst_n), .conv_en_i(conv_en), .auto_en_i(auto_en),
    .src_sel_i(sel), .flags_i(flags), .conv_done_i(done), .busy_i(busy),
    .start_o(start)
  );

  // {auto, conv, sel[2:0], flags[5:0], done, busy, expected start}
  localparam int NV = 36;
  localparam logic [13:0] VEC [0:NV-1] = '{
    {2'b11, 3'd1, 6'b000000, 2'b00, 1'b0},
    {2'b11, 3'd1, 6'b000001, 2'b00, 1'b1},
    {2'b11, 3'd1, 6'b000001, 2'b00, 1'b0},
    {2'b11, 3'd1, 6'b000011, 2'b00, 1'b0},
    {2'b11, 3'd2, 6'b000011, 2'b00, 1'b0},
    {2'b11, 3'd3, 6'b000011, 2'b00, 1'b0},
    {2'b11, 3'd3, 6'b000111, 2'b00, 1'b1},
    {2'b11, 3'd4, 6'b000111, 2'b00, 1'b0},
    {2'b11, 3'd4, 6'b001111, 2'b00, 1'b1},
    {2'b11, 3'd5, 6'b001111, 2'b00, 1'b0},
    {2'b11, 3'd6, 6'b101111, 2'b00, 1'b1},
    {2'b11, 3'd5, 6'b111111, 2'b00, 1'b0},
    {2'b11, 3'd5, 6'b000000, 2'b00, 1'b0},
    {2'b11, 3'd5, 6'b010000, 2'b00, 1'b1},
    {2'b11, 3'd7, 6'b111111, 2'b00, 1'b0},
    {2'b11, 3'd7, 6'b000000, 2'b00, 1'b0},
    {2'b11, 3'd7, 6'b111111, 2'b00, 1'b0},
    {2'b01, 3'd1, 6'b000000, 2'b00, 1'b0},
    {2'b01, 3'd1, 6'b000001, 2'b00, 1'b0},
    {2'b11, 3'd1, 6'b000001, 2'b00, 1'b0},
    {2'b11, 3'd1, 6'b000000, 2'b00, 1'b0},
    {2'b10, 3'd1, 6'b000001, 2'b00, 1'b0},
    {2'b11, 3'd1, 6'b000001, 2'b00, 1'b0},
    {2'b11, 3'd1, 6'b000000, 2'b00, 1'b0},
    {2'b11, 3'd1, 6'b000001, 2'b01, 1'b0},
    {2'b11, 3'd1, 6'b000001, 2'b00, 1'b0},
    {2'b11, 3'd1, 6'b000000, 2'b10, 1'b0},
    {2'b11, 3'd0, 6'b000000, 2'b10, 1'b0},
    {2'b11, 3'd0, 6'b000000, 2'b00, 1'b0},
    {2'b11, 3'd0, 6'b000000, 2'b10, 1'b1},
    {2'b11, 3'd0, 6'b000000, 2'b10, 1'b0},
    {2'b01, 3'd0, 6'b000000, 2'b00, 1'b0},
    {2'b01, 3'd0, 6'b000000, 2'b10, 1'b0},
    {2'b11, 3'd2, 6'b000000, 2'b10, 1'b0},
    {2'b11, 3'd2, 6'b000010, 2'b10, 1'b1},
    {2'b11, 3'd0, 6'b000010, 2'b00, 1'b0}
  };

  localparam string TAG [0:NV-1] = '{
    "R3", "R2", "R3", "R3", "R3", "R3", "R2", "R3", "R2", "R3",
    "R6", "R3", "R3", "R2", "R10", "R10", "R10", "R4", "R4", "R4",
    "R3", "R5", "R5", "R3", "R9", "R9", "R3", "R7", "R8", "R8",
    "R11", "R8", "R8", "R3", "R2", "R7"
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: start_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int cnt;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", start, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check(TAG[i], start, VEC[i-1 < 0 ? 0 : i-1][0] & (i != 0));
      {auto_en, conv_en} = {VEC[i][13], VEC[i][12]};
      sel   = VEC[i][11:9];
      flags = VEC[i][8:3];
      done  = VEC[i][2];
      busy  = VEC[i][1];
    end
    @(negedge clk);
    check(TAG[NV-1], start, VEC[NV-1][0]);

    // R1: flag held high through reset fires once after release
    rst_n = 1'b0;
    auto_en = 1'b1; conv_en = 1'b1; sel = 3'd1; flags = 6'b000001; done = 1'b0; busy = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", start, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", start, 1'b1);
    @(negedge clk);
    check("R11", start, 1'b0);

    // R8: free running with a modelled converter, ten conversions
    flags = 6'd0;
    sel = 3'd0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    cnt = 0;
    for (int k = 0; k < 10; k++) begin
      int w;
      w = 0;
      do begin
        @(negedge clk);
        w++;
      end while (!start && w < 8);
      if (start) cnt++;
      done = 1'b0;
      busy = 1'b1;
      repeat (3) @(negedge clk);
      busy = 1'b0;
      done = (k < 9);
    end
    checks++;
    if (cnt != 10) begin
      errors++;
      $display("FAIL R8: free-running starts=%0d expected 10", cnt);
    end

    finish_run();
  end
endmodule